// File: doc/BRIEF.md
# Exhaustive Key Search Controller

This block runs a brute-force key sweep against a pipelined cipher checker. The checker takes one candidate key per clock and returns the two 32-bit ciphertext words for that key a fixed number of cycles later. The controller makes the candidates from a running counter that starts at a loaded base value. It tracks which key each returned result belongs to. It compares every result with a 64-bit target ciphertext. It stops either on a hit, holding the winning key, or after the last candidate up to a programmable limit has drained out of the checker.

A shadow line of valid bits and keys runs beside the checker and has the same latency. A result is considered only when its shadow entry is valid, so the results that come out while the checker fills after a start are ignored. Results left in the checker by an earlier search are ignored in the same way. A start pulse loads the base, the limit and the target. It also clears the shadow line and any earlier outcome, so it can restart a search at any time.

Top module: `keysweep_ctrl`

## Requirements
- R1: After reset, `busy`, `found`, `exhausted` and `key_vld` are low and `win_key` is zero.
- R2: In the cycle after `start`, `busy` is high, `key_vld` is high (when base <= limit), and the presented key equals `base_key`. Word 0 (`key_w0`) carries key bits [31:0] and word 1 (`key_w1`) carries the bits above them.
- R3: While `key_vld` stays high, the presented key rises by exactly one each cycle, with the carry passing from word 0 into word 1. The last key presented equals `limit_key`. `key_vld` then drops and the key holds at the limit.
- R4: Any result that arrives while the checker fills after a start is ignored, even if it equals the target.
- R5: A result matches only when `res_ct0` equals `target_ct[31:0]` and `res_ct1` equals `target_ct[63:32]`. A result that matches in one word only is ignored.
- R6: The result seen in cycle t belongs to the key presented in cycle t-LATENCY. On a match, `found` rises in the next cycle and `win_key` holds that key.
- R7: After a match, `key_vld` is low and `busy` is low. `found` and `win_key` hold until the next `start`. Later results have no effect.
- R8: With no match, `exhausted` rises LATENCY+2 cycles after the cycle in which the limit key was presented, and `busy` falls at the same time.
- R9: If base > limit, no key is presented and `exhausted` rises two cycles after `start`.
- R10: A `start` during a search restarts it: results of keys issued before the restart are discarded, and any earlier `found` or `exhausted` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | One-cycle pulse that loads the search parameters and starts a search |
| base_key | input | KEY_W | First candidate key |
| limit_key | input | KEY_W | Last candidate key |
| target_ct | input | 64 | Target ciphertext, word 1 in bits [63:32] |
| key_w0 | output | 32 | Candidate key bits [31:0] to the checker |
| key_w1 | output | KEY_W-32 | Candidate key upper bits to the checker |
| key_vld | output | 1 | Candidate key is part of the sweep |
| res_ct0 | input | 32 | Checker result word 0 |
| res_ct1 | input | 32 | Checker result word 1 |
| busy | output | 1 | Search in progress |
| found | output | 1 | A matching key was found |
| exhausted | output | 1 | The sweep ended with no match |
| win_key | output | KEY_W | The key whose result matched |

## Verification
The presented key is due in the cycle after `start` and then advances once per clock. `found` is due one cycle after the matching result, which is LATENCY+1 cycles after the winning key was presented. `exhausted` is due LATENCY+2 cycles after the limit key. The bench runs a queue-based model that records the cycle in which each issued key's result falls due. It updates that model between edges using the inputs applied in that cycle, and compares every output after each rising edge. The bench's checker delay line starts full of target-equal results, so fill-time garbage is present in every run.

// File: rtl/keysweep_pkg.sv
package keysweep_pkg;
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_RUN  = 2'd1,
        KS_HIT  = 2'd2,
        KS_DRY  = 2'd3
    } ks_state_e;
endpackage

// File: rtl/ks_keygen.sv
module ks_keygen #(
    parameter int KEY_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             halt,
    input  logic [KEY_W-1:0] base,
    input  logic [KEY_W-1:0] limit,
    output logic [KEY_W-1:0] key,
    output logic             on
);
    typedef struct packed {
        logic [KEY_W-1:0] cnt;
        logic [KEY_W-1:0] lim;
        logic             on;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (load) begin
            g_d.cnt = base;
            g_d.lim = limit;
            g_d.on  = (base <= limit);
        end else if (halt) begin
            g_d.on = 1'b0;
        end else if (g_q.on) begin
            if (g_q.cnt == g_q.lim) g_d.on = 1'b0;
            else                    g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign key = g_q.cnt;
    assign on  = g_q.on;
endmodule

// File: rtl/ks_shadow.sv
module ks_shadow #(
    parameter int LAT   = 12,
    parameter int KEY_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_vld,
    input  logic [KEY_W-1:0] in_key,
    output logic             tail_vld,
    output logic [KEY_W-1:0] tail_key,
    output logic             any_vld
);
    localparam int LAST = LAT - 1;

    logic [LAT-1:0]   vld_d, vld_q;
    logic [KEY_W-1:0] key_d [LAT];
    logic [KEY_W-1:0] key_q [LAT];

    assign vld_d[0] = !flush && in_vld;
    assign key_d[0] = in_key;

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        assign vld_d[s] = !flush && vld_q[s-1];
        assign key_d[s] = key_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        key_q <= key_d;
    end

    assign tail_vld = vld_q[LAST];
    assign tail_key = key_q[LAST];
    assign any_vld  = |vld_q;
endmodule

// File: rtl/ks_match.sv
module ks_match (
    input  logic        tail_vld,
    input  logic [63:0] tgt,
    input  logic [31:0] ct0,
    input  logic [31:0] ct1,
    output logic        hit
);
    assign hit = tail_vld && (ct0 == tgt[31:0]) && (ct1 == tgt[63:32]);
endmodule

// File: rtl/keysweep_ctrl.sv
module keysweep_ctrl
    import keysweep_pkg::*;
#(
    parameter int KEY_W   = 64,
    parameter int LATENCY = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KEY_W-1:0]  base_key,
    input  logic [KEY_W-1:0]  limit_key,
    input  logic [63:0]       target_ct,
    output logic [31:0]       key_w0,
    output logic [KEY_W-33:0] key_w1,
    output logic              key_vld,
    input  logic [31:0]       res_ct0,
    input  logic [31:0]       res_ct1,
    output logic              busy,
    output logic              found,
    output logic              exhausted,
    output logic [KEY_W-1:0]  win_key
);
    localparam int HI_W = KEY_W - 32;

    typedef struct packed {
        ks_state_e        st;
        logic [63:0]      tgt;
        logic [KEY_W-1:0] win;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic [KEY_W-1:0] cur_key, tail_key;
    logic             key_on, tail_vld, any_vld, hit;
    logic             flush, halt;

    ks_keygen #(.KEY_W(KEY_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .load(start), .halt(halt),
        .base(base_key), .limit(limit_key), .key(cur_key), .on(key_on)
    );

    ks_shadow #(.LAT(LATENCY), .KEY_W(KEY_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_vld(key_on),
        .in_key(cur_key), .tail_vld(tail_vld), .tail_key(tail_key),
        .any_vld(any_vld)
    );

    ks_match u_match (
        .tail_vld(tail_vld), .tgt(c_q.tgt), .ct0(res_ct0), .ct1(res_ct1),
        .hit(hit)
    );

    always_comb begin
        c_d   = c_q;
        halt  = 1'b0;
        flush = start;
        if (start) begin
            c_d.st  = KS_RUN;
            c_d.tgt = target_ct;
            c_d.win = '0;
        end else if (c_q.st == KS_RUN) begin
            if (hit) begin
                c_d.st  = KS_HIT;
                c_d.win = tail_key;
                halt    = 1'b1;
                flush   = 1'b1;
            end else if (!key_on && !any_vld) begin
                c_d.st = KS_DRY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: KS_IDLE, tgt: '0, win: '0};
        else        c_q <= c_d;
    end

    assign key_w0    = cur_key[31:0];
    assign key_w1    = cur_key[KEY_W-1 -: HI_W];
    assign key_vld   = key_on;
    assign busy      = (c_q.st == KS_RUN);
    assign found     = (c_q.st == KS_HIT);
    assign exhausted = (c_q.st == KS_DRY);
    assign win_key   = c_q.win;
endmodule

// File: rtl/keysweep_ctrl_chk.sv
module keysweep_ctrl_chk #(
    parameter int KEY_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [31:0]       key_w0,
    input logic [KEY_W-33:0] key_w1,
    input logic              key_vld,
    input logic              busy,
    input logic              found,
    input logic              exhausted,
    input logic [KEY_W-1:0]  win_key
);
    logic [KEY_W-1:0] key;
    assign key = {key_w1, key_w0};

    // R3
    key_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_vld && !start) |=> (!key_vld || key == $past(key) + 1'b1));

    // R7
    found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !start) |=> (found && $stable(win_key)));

    // R7
    halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found || exhausted) |-> !key_vld);

    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, found, exhausted}));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !found && !exhausted));
endmodule

bind keysweep_ctrl keysweep_ctrl_chk #(.KEY_W(KEY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .key_w0(key_w0),
    .key_w1(key_w1), .key_vld(key_vld), .busy(busy), .found(found),
    .exhausted(exhausted), .win_key(win_key)
);

// File: tb/keysweep_ctrl_test.sv
module keysweep_ctrl_test;
    localparam int KEY_W = 64;
    localparam int LAT   = 12;
    localparam logic [63:0] TGT = 64'hDEAD_BEEF_0BAD_F00D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [KEY_W-1:0]  base_key = '0, limit_key = '0;
    logic [63:0]       target_ct = TGT;
    logic [31:0]       key_w0;
    logic [KEY_W-33:0] key_w1;
    logic              key_vld, busy, found, exhausted;
    logic [31:0]       res_ct0, res_ct1;
    logic [KEY_W-1:0]  win_key;

    always #2 clk = ~clk;

    keysweep_ctrl #(.KEY_W(KEY_W), .LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_key(base_key),
        .limit_key(limit_key), .target_ct(target_ct), .key_w0(key_w0),
        .key_w1(key_w1), .key_vld(key_vld), .res_ct0(res_ct0),
        .res_ct1(res_ct1), .busy(busy), .found(found),
        .exhausted(exhausted), .win_key(win_key)
    );

    // checker stand-in: fixed delay line with programmable keys
    logic [63:0] match_key = '0, half0_key = '1, half1_key = '1;
    logic [63:0] line [LAT];

    function automatic logic [63:0] ct_of(input logic [63:0] k);
        if (k == match_key) return TGT;
        if (k == half0_key) return {~TGT[63:32], TGT[31:0]};
        if (k == half1_key) return {TGT[63:32], ~TGT[31:0]};
        return {k[31:0] ^ 32'h5A5A_1234, k[63:32] ^ 32'h0F0F_0F0F};
    endfunction

    always_ff @(posedge clk) begin
        line[0] <= ct_of({key_w1, key_w0});
        for (int i = 1; i < LAT; i++) line[i] <= line[i-1];
    end
    assign {res_ct1, res_ct0} = line[LAT-1];

    // reference model
    int          checks = 0, errors = 0;
    int          m_st = 0;
    bit          m_on = 0;
    logic [63:0] m_cnt = '0, m_lim = '0, m_tgt = '0, m_win = '0;
    logic [63:0] qk[$];
    longint      qd[$];
    longint      cyc = 0;
    bit          done = 0;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                       input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk({63'd0, key_vld}, {63'd0, m_on}, "R3 key_vld");
        chk({key_w1, key_w0}, m_cnt, "R3 key");
        chk({63'd0, busy}, {63'd0, m_st == 1}, "R8 busy");
        chk({63'd0, found}, {63'd0, m_st == 2}, "R6 found");
        chk({63'd0, exhausted}, {63'd0, m_st == 3}, "R8 exhausted");
        chk(win_key, m_win, "R6 win_key");
    endtask

    task automatic step();
        logic [63:0] res;
        bit hit;
        res = {res_ct1, res_ct0};
        if (start) begin
            m_cnt = base_key; m_lim = limit_key; m_on = (base_key <= limit_key);
            m_tgt = target_ct; m_st = 1; m_win = '0;
            qk.delete(); qd.delete();
        end else begin
            hit = (m_st == 1) && qk.size() > 0 && qd[0] == cyc && res == m_tgt;
            if (m_st == 1) begin
                if (hit) begin
                    m_st = 2; m_win = qk[0]; m_on = 0;
                    qk.delete(); qd.delete();
                end else if (!m_on && qk.size() == 0) begin
                    m_st = 3;
                end
            end
            if (m_on) begin
                qk.push_back(m_cnt); qd.push_back(cyc + LAT);
                if (m_cnt == m_lim) m_on = 0;
                else m_cnt = m_cnt + 1;
            end
            if (qd.size() > 0 && qd[0] == cyc) begin
                void'(qk.pop_front()); void'(qd.pop_front());
            end
        end
        cyc++;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic go(input logic [63:0] b, input logic [63:0] l);
        base_key = b; limit_key = l; start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic run_out();
        for (int n = 0; n < 2000 && !found && !exhausted; n++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] b;
        repeat (LAT + 3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({60'd0, busy, found, exhausted, key_vld}, 64'd0, "R1 flags");
        chk(win_key, 64'd0, "R1 win_key");
        step();

        // R2 / R4: line holds target-equal garbage for key 0
        match_key = 64'd0;
        b = 64'h0000_0005_FFFF_FFF0;
        go(b, b + 32);
        chk({32'd0, key_w0}, 64'h0000_0000_FFFF_FFF0, "R2 word0");
        chk({32'd0, key_w1}, 64'd5, "R2 word1");
        chk({63'd0, key_vld}, 64'd1, "R2 key_vld");
        run_out();
        chk({63'd0, found}, 64'd0, "R4 garbage ignored");
        chk({63'd0, exhausted}, 64'd1, "R8 exhausted");
        chk({key_w1, key_w0}, b + 32, "R3 held at limit");

        // R6 / R7 match and hold
        b = 64'h1234_0000_0000_0100;
        match_key = b + 7;
        go(b, b + 100);
        run_out();
        chk({63'd0, found}, 64'd1, "R6 found");
        chk(win_key, b + 7, "R6 win_key");
        for (int i = 0; i < 20; i++) step();
        chk({62'd0, found, key_vld}, 64'd2, "R7 held halted");
        chk(win_key, b + 7, "R7 win held");

        // R5 single-word matches ignored
        b = 64'h0000_0000_7000_0000;
        half0_key = b + 2; half1_key = b + 4; match_key = b + 9;
        go(b, b + 40);
        run_out();
        chk(win_key, b + 9, "R5 both words");
        half0_key = '1; half1_key = '1;

        // R9 base above limit
        go(64'd100, 64'd50);
        chk({63'd0, key_vld}, 64'd0, "R9 no key");
        step();
        chk({63'd0, exhausted}, 64'd1, "R9 exhausted");

        // R10 restart mid-search
        match_key = 64'h0000_0000_0000_0203;
        go(64'h0000_0000_0000_0200, 64'h0000_0000_0000_0300);
        for (int i = 0; i < 5; i++) step();
        match_key = 64'h0000_0000_0009_0003;
        go(64'h0000_0000_0009_0000, 64'h0000_0000_0009_0100);
        run_out();
        chk(win_key, 64'h0000_0000_0009_0003, "R10 restart win");

        // R3 match on the limit key itself
        b = 64'h0000_0001_0000_0000;
        match_key = b + 15;
        go(b, b + 15);
        run_out();
        chk({62'd0, found, exhausted}, 64'd2, "R3 limit key searched");
        chk(win_key, b + 15, "R3 limit win");

        // R3 limit at all ones, no wrap past it
        match_key = 64'd0;
        go(64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFF);
        run_out();
        chk({63'd0, exhausted}, 64'd1, "R8 top exhausted");
        chk({key_w1, key_w0}, 64'hFFFF_FFFF_FFFF_FFFF, "R3 no wrap");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule